// File: doc/BRIEF.md
# Write-Hit Counting Test Peripheral

This block is a bus test target that exposes two byte-wide windows on one shared access port. One is a memory-style window and the other is an I/O-style window. Software picks one of six test profiles by writing a small number to offset 0 of either window. While a profile is active, the block counts writes that land on that profile's trigger offset. Some profiles count a write whatever its data. Others count it only when it is a single-byte write of one particular data value.

Each profile has a header that is read back byte by byte. The header holds:
- the profile index and the access width;
- the trigger offset and the match byte;
- a 32-bit little-endian hit counter;
- an ASCII name.

A host-side test writes to offset 0 to start a run, issues its accesses, and then reads bytes 12 to 15 to see how many of them reached the trigger.

Reads take one cycle. The byte requested while `bus_rd` is high appears on `bus_rdata` after the next rising clock edge, and `bus_rdata` is 0 in any cycle that follows no read. Only one of `bus_wr` and `bus_rd` is high in a cycle.

Top module: `hitcount_probe`

## Requirements
- R1: After reset no profile is active. Every read, on either window and at any offset, returns 0.
- R2: A write to offset 0 with a value v below 3 makes profile p = window*3 + v active, where window is 0 for the memory window and 1 for the I/O window. It also clears the hit count to 0. Header byte 0 then reads p.
- R3: A write to offset 0 with a value of 3 or more leaves no profile active, so later reads return 0. A write to offset 0 is never counted as a hit, and reselecting a profile restarts its count at 0.
- R4: Kind 1 (wildcard) counts by 1 each write at the trigger offset, whatever the data value or access size.
- R5: Kinds 0 and 2 count a write at the trigger offset only if its access size is 1 and its data is 0xFA. Any other size or data leaves the count unchanged.
- R6: Writes that miss the trigger offset do not change the count, and neither does any write while no profile is active.
- R7: The trigger offset of profile p is the window base plus p. The memory base is 2048 and the I/O base is 128. The offset is held little-endian in header bytes 4 to 7. The memory window decodes 12 address bits and the I/O window decodes the low 8 bits. A write on either window is compared with the trigger offset.
- R8: Header byte 1 reads 1. Byte 8 reads 0xCE for kind 1 and 0xFA for kinds 0 and 2. Padding bytes 2, 3, 9, 10 and 11 read 0.
- R9: The hit count reads back little-endian in header bytes 12 to 15, with the least significant byte at 12.
- R10: The name starts at byte 16 and has the form "mmio-" or "portio-" (by window), followed by "no-eventfd", "wildcard-eventfd" or "datamatch-eventfd" (by kind 0, 1, 2). The header length L is 17 plus the name length. A read at offset a with size s returns 0 when a + s is L or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one access |
| bus_rd | input | 1 | Read strobe for one access |
| bus_win | input | 1 | Window select: 0 memory, 1 I/O |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 8 | Write data byte |
| bus_size | input | 3 | Access size in bytes |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |

## Verification
The hardest case to reach is a hit from an address form that looks wrong. One example is a write on the memory window at the I/O profile's trigger offset. Another is an I/O write whose upper address bits are set but ignored. The bench sets up an I/O data-match profile and sends the matching byte through both of these paths and the plain one, then checks that the count rose by exactly three. A second hard case is the header-length edge, where a read of a valid last name character returns 0 once the access size pushes its end onto the length. The bench reads that character once with size 1 and once with size 2. A third is a carry out of the low count byte, which needs 257 wildcard hits before bytes 12 and 13 can both be seen as 1.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    localparam int unsigned NUM_KINDS = 3;
    localparam int unsigned HDR_FIXED = 16;
    localparam int unsigned STR_CHARS = 17;
    localparam int unsigned STR_W     = 8 * STR_CHARS;

    typedef enum logic [1:0] {
        KIND_QUIET = 2'd0,
        KIND_ANY   = 2'd1,
        KIND_EXACT = 2'd2
    } kind_e;

    localparam logic [STR_W-1:0] PFX_MEM   = {{(STR_CHARS-5)*8{1'b0}}, "mmio-"};
    localparam logic [STR_W-1:0] PFX_IO    = {{(STR_CHARS-7)*8{1'b0}}, "portio-"};
    localparam logic [STR_W-1:0] SFX_QUIET = {{(STR_CHARS-10)*8{1'b0}}, "no-eventfd"};
    localparam logic [STR_W-1:0] SFX_ANY   = {{(STR_CHARS-16)*8{1'b0}}, "wildcard-eventfd"};
    localparam logic [STR_W-1:0] SFX_EXACT = "datamatch-eventfd";

    // Character k of a right-justified packed string of len characters.
    function automatic logic [7:0] str_byte(logic [STR_W-1:0] s, int unsigned len,
                                            int unsigned k);
        logic [STR_W-1:0] t;
        t = s >> (8 * (len - 1 - k));
        return t[7:0];
    endfunction

    function automatic int unsigned pfx_len(logic win);
        return win ? 7 : 5;
    endfunction

    function automatic int unsigned sfx_len(kind_e kind);
        case (kind)
            KIND_QUIET: return 10;
            KIND_ANY:   return 16;
            default:    return 17;
        endcase
    endfunction

    function automatic int unsigned name_len(logic win, kind_e kind);
        return pfx_len(win) + sfx_len(kind);
    endfunction

    function automatic logic [7:0] name_char(logic win, kind_e kind, int unsigned k);
        logic [STR_W-1:0] sfx;
        int unsigned      pl;
        pl = pfx_len(win);
        case (kind)
            KIND_QUIET: sfx = SFX_QUIET;
            KIND_ANY:   sfx = SFX_ANY;
            default:    sfx = SFX_EXACT;
        endcase
        if (k < pl) return str_byte(win ? PFX_IO : PFX_MEM, pl, k);
        return str_byte(sfx, sfx_len(kind), k - pl);
    endfunction

    function automatic logic [7:0] prof_index(logic win, kind_e kind);
        return 8'(32'(win) * NUM_KINDS + 32'(kind));
    endfunction

    function automatic logic [31:0] trig_off(logic win, kind_e kind,
                                             int unsigned mem_base, int unsigned io_base);
        int unsigned base;
        base = win ? io_base : mem_base;
        return 32'(base + 32'(prof_index(win, kind)));
    endfunction

endpackage

// File: rtl/hcp_window_decode.sv
module hcp_window_decode #(
    parameter int unsigned MEM_W = 12,
    parameter int unsigned IO_W  = 8
) (
    input  logic             win,
    input  logic [MEM_W-1:0] addr,
    output logic [MEM_W-1:0] off,
    output logic             is_ctrl
);
    logic [MEM_W-1:0] io_off;

    generate
        if (IO_W < MEM_W) begin : g_fold
            assign io_off = {{(MEM_W-IO_W){1'b0}}, addr[IO_W-1:0]};
        end else begin : g_flat
            assign io_off = addr;
        end
    endgenerate

    assign off     = win ? io_off : addr;
    assign is_ctrl = (off == '0);
endmodule

// File: rtl/hcp_hit_match.sv
module hcp_hit_match
    import hcp_pkg::*;
#(
    parameter int unsigned MEM_W      = 12,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SIZE_W     = 3,
    parameter int unsigned MEM_BASE   = 2048,
    parameter int unsigned IO_BASE    = 128,
    parameter logic [7:0]  MATCH_BYTE = 8'hFA
) (
    input  logic              active,
    input  logic              prof_win,
    input  kind_e             prof_kind,
    input  logic [MEM_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SIZE_W-1:0] size,
    output logic              hit
);
    logic [31:0] trig;
    logic        addr_ok;
    logic        data_ok;

    always_comb begin
        trig    = trig_off(prof_win, prof_kind, MEM_BASE, IO_BASE);
        addr_ok = (32'(off) == trig);
        data_ok = (prof_kind == KIND_ANY) ||
                  ((size == SIZE_W'(1)) && (wdata == DATA_W'(MATCH_BYTE)));
        hit     = active && addr_ok && data_ok;
    end
endmodule

// File: rtl/hcp_header_rom.sv
module hcp_header_rom
    import hcp_pkg::*;
#(
    parameter int unsigned MEM_W      = 12,
    parameter int unsigned SIZE_W     = 3,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned MEM_BASE   = 2048,
    parameter int unsigned IO_BASE    = 128,
    parameter logic [7:0]  MATCH_BYTE = 8'hFA,
    parameter logic [7:0]  WILD_BYTE  = 8'hCE
) (
    input  logic              active,
    input  logic              prof_win,
    input  kind_e             prof_kind,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [MEM_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output logic [7:0]        byte_o
);
    logic [31:0] trig;
    logic [31:0] cnt32;
    int unsigned o;
    int unsigned nlen;
    int unsigned hlen;

    always_comb begin
        trig   = trig_off(prof_win, prof_kind, MEM_BASE, IO_BASE);
        cnt32  = 32'(cnt);
        o      = 32'(off);
        nlen   = name_len(prof_win, prof_kind);
        hlen   = HDR_FIXED + nlen + 1;
        byte_o = 8'h00;
        if (active && (o + 32'(size) < hlen)) begin
            case (o)
                0:       byte_o = prof_index(prof_win, prof_kind);
                1:       byte_o = 8'h01;
                4:       byte_o = trig[7:0];
                5:       byte_o = trig[15:8];
                6:       byte_o = trig[23:16];
                7:       byte_o = trig[31:24];
                8:       byte_o = (prof_kind == KIND_ANY) ? WILD_BYTE : MATCH_BYTE;
                12:      byte_o = cnt32[7:0];
                13:      byte_o = cnt32[15:8];
                14:      byte_o = cnt32[23:16];
                15:      byte_o = cnt32[31:24];
                default: begin
                    if (o >= HDR_FIXED && (o - HDR_FIXED) < nlen)
                        byte_o = name_char(prof_win, prof_kind, o - HDR_FIXED);
                end
            endcase
        end
    end
endmodule

// File: rtl/hitcount_probe.sv
module hitcount_probe
    import hcp_pkg::*;
#(
    parameter int unsigned MEM_BASE   = 2048,
    parameter int unsigned IO_BASE    = 128,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SIZE_W     = 3,
    parameter logic [7:0]  MATCH_BYTE = 8'hFA,
    parameter logic [7:0]  WILD_BYTE  = 8'hCE,
    localparam int unsigned MEM_W     = $clog2(2 * MEM_BASE),
    localparam int unsigned IO_W      = $clog2(2 * IO_BASE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_win,
    input  logic [MEM_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SIZE_W-1:0] bus_size,
    output logic [7:0]        bus_rdata
);
    typedef struct packed {
        logic             active;
        logic             win;
        kind_e            kind;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       rdata;
    } state_t;

    state_t st_d, st_q;

    logic [MEM_W-1:0] off;
    logic             is_ctrl;
    logic             hit;
    logic [7:0]       hdr_byte;
    logic             prof_active;
    logic [CNT_W-1:0] hit_cnt;

    hcp_window_decode #(.MEM_W(MEM_W), .IO_W(IO_W)) u_decode (
        .win     (bus_win),
        .addr    (bus_addr),
        .off     (off),
        .is_ctrl (is_ctrl)
    );

    hcp_hit_match #(
        .MEM_W(MEM_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
        .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE), .MATCH_BYTE(MATCH_BYTE)
    ) u_match (
        .active    (st_q.active),
        .prof_win  (st_q.win),
        .prof_kind (st_q.kind),
        .off       (off),
        .wdata     (bus_wdata),
        .size      (bus_size),
        .hit       (hit)
    );

    hcp_header_rom #(
        .MEM_W(MEM_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
        .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE),
        .MATCH_BYTE(MATCH_BYTE), .WILD_BYTE(WILD_BYTE)
    ) u_header (
        .active    (st_q.active),
        .prof_win  (st_q.win),
        .prof_kind (st_q.kind),
        .cnt       (st_q.cnt),
        .off       (off),
        .size      (bus_size),
        .byte_o    (hdr_byte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = 8'h00;
        if (bus_rd) begin
            st_d.rdata = hdr_byte;
        end
        if (bus_wr) begin
            if (is_ctrl) begin
                st_d.active = 1'b0;
                if (bus_wdata < DATA_W'(NUM_KINDS)) begin
                    st_d.active = 1'b1;
                    st_d.win    = bus_win;
                    st_d.kind   = kind_e'(bus_wdata[1:0]);
                    st_d.cnt    = '0;
                end
            end else if (hit) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign prof_active = st_q.active;
    assign hit_cnt     = st_q.cnt;
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
    parameter int unsigned MEM_W  = 12,
    parameter int unsigned IO_W   = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_win,
    input logic [MEM_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SIZE_W-1:0] bus_size,
    input logic [7:0]        bus_rdata,
    input logic              prof_active,
    input logic [CNT_W-1:0]  hit_cnt
);
    logic at_zero;
    logic at_one;
    logic ctrl_wr;

    always_comb begin
        at_zero = bus_win ? (bus_addr[IO_W-1:0] == '0) : (bus_addr == '0);
        at_one  = bus_win ? (bus_addr[IO_W-1:0] == IO_W'(1)) : (bus_addr == MEM_W'(1));
        ctrl_wr = bus_wr && at_zero;
    end

    p_ctrl_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata < DATA_W'(3)) |=> (prof_active && hit_cnt == '0));

    p_ctrl_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata >= DATA_W'(3)) |=> !prof_active);

    p_idle_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !prof_active) |=> (bus_rdata == 8'h00));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !at_zero) |=>
        (hit_cnt == $past(hit_cnt) || hit_cnt == $past(hit_cnt) + CNT_W'(1)));

    p_idle_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !at_zero && !prof_active) |=> $stable(hit_cnt));

    p_no_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(hit_cnt));

    p_width_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && prof_active && at_one && bus_size == SIZE_W'(1)) |=> (bus_rdata == 8'h01));
endmodule

bind hitcount_probe hcp_checker #(
    .MEM_W(MEM_W), .IO_W(IO_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_win     (bus_win),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_size    (bus_size),
    .bus_rdata   (bus_rdata),
    .prof_active (prof_active),
    .hit_cnt     (hit_cnt)
);

// File: tb/hitcount_probe_tb.sv
module hitcount_probe_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_win = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [2:0]  bus_size = 3'd1;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    hitcount_probe u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic win, input int addr, input logic [7:0] data,
                      input logic [2:0] size);
        @(negedge clk);
        bus_win = win; bus_addr = 12'(addr); bus_wdata = data; bus_size = size; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic win, input int addr, input logic [2:0] size,
                      output logic [7:0] v);
        @(negedge clk);
        bus_win = win; bus_addr = 12'(addr); bus_size = size; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [31:0] c);
        logic [7:0] b;
        c = '0;
        for (int k = 0; k < 4; k++) begin
            rd(1'b0, 12 + k, 3'd1, b);
            c[8*k +: 8] = b;
        end
    endtask

    task automatic sel(input int p);
        wr(p >= 3, 0, 8'(p % 3), 3'd1);
    endtask

    function automatic string pname(int p);
        string kinds[3] = '{"no-eventfd", "wildcard-eventfd", "datamatch-eventfd"};
        return {(p >= 3) ? "portio" : "mmio", "-", kinds[p % 3]};
    endfunction

    function automatic int trig(int p);
        return ((p >= 3) ? 128 : 2048) + p;
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, 0, 3'd1, v);  chk("R1 idle mem byte0", 32'(v), 0);
        rd(1'b0, 1, 3'd1, v);  chk("R1 idle mem byte1", 32'(v), 0);
        rd(1'b1, 0, 3'd1, v);  chk("R1 idle io byte0", 32'(v), 0);
        rd(1'b0, 16, 3'd1, v); chk("R1 idle name", 32'(v), 0);
    endtask

    task automatic t_select;
        logic [7:0]  v;
        logic [31:0] c;
        for (int p = 0; p < 6; p++) begin
            sel(p);
            rd(1'b0, 0, 3'd1, v); chk($sformatf("R2 index p%0d", p), 32'(v), 32'(p));
            rd(1'b1, 1, 3'd1, v); chk("R8 width byte", 32'(v), 1);
            rd(1'b0, 8, 3'd1, v); chk("R8 match byte", 32'(v), (p % 3 == 1) ? 32'hCE : 32'hFA);
            rd(1'b0, 2, 3'd1, v);  chk("R8 pad2", 32'(v), 0);
            rd(1'b0, 10, 3'd1, v); chk("R8 pad10", 32'(v), 0);
            rd(1'b0, 4, 3'd1, v); chk("R7 trig byte4", 32'(v), trig(p) & 32'hFF);
            rd(1'b0, 5, 3'd1, v); chk("R7 trig byte5", 32'(v), (trig(p) >> 8) & 32'hFF);
            rd(1'b0, 7, 3'd1, v); chk("R7 trig byte7", 32'(v), 0);
            rd_cnt(c); chk("R2 count cleared", c, 0);
        end
    endtask

    task automatic t_name;
        logic [7:0] v;
        for (int p = 0; p < 6; p++) begin
            string n = pname(p);
            int    len = 17 + n.len();
            sel(p);
            for (int k = 0; k < n.len(); k++) begin
                rd(p >= 3, 16 + k, 3'd1, v);
                chk($sformatf("R10 name p%0d c%0d", p, k), 32'(v), 32'(n[k]));
            end
            rd(1'b0, len - 2, 3'd2, v); chk("R10 end reached by size", 32'(v), 0);
            rd(1'b0, len - 1, 3'd1, v); chk("R10 terminator", 32'(v), 0);
            rd(1'b0, len, 3'd1, v);     chk("R10 beyond length", 32'(v), 0);
            rd(1'b0, 0, 3'd4, v);       chk("R10 wide read in range", 32'(v), 32'(p));
        end
    endtask

    task automatic t_wild;
        logic [31:0] c;
        sel(1);
        wr(1'b0, 2049, 8'h00, 3'd1);
        wr(1'b0, 2049, 8'h55, 3'd4);
        wr(1'b0, 2049, 8'hFA, 3'd2);
        rd_cnt(c); chk("R4 wildcard any data and size", c, 3);
        wr(1'b0, 2050, 8'h00, 3'd1);
        wr(1'b0, 2048, 8'h00, 3'd1);
        rd_cnt(c); chk("R6 off-trigger ignored", c, 3);
    endtask

    task automatic t_match;
        logic [31:0] c;
        sel(2);
        wr(1'b0, 2050, 8'hFA, 3'd1);
        wr(1'b0, 2050, 8'hFB, 3'd1);
        wr(1'b0, 2050, 8'hFA, 3'd2);
        wr(1'b0, 2050, 8'hCE, 3'd1);
        rd_cnt(c); chk("R5 datamatch kind 2", c, 1);
        sel(0);
        wr(1'b0, 2048, 8'hCE, 3'd1);
        wr(1'b0, 2048, 8'hFA, 3'd1);
        wr(1'b0, 2048, 8'hFA, 3'd4);
        rd_cnt(c); chk("R5 quiet kind 0 matches data", c, 1);
        sel(5);
        wr(1'b1, 133, 8'hFA, 3'd1);
        wr(1'b1, 12'hF85, 8'hFA, 3'd1);
        wr(1'b0, 133, 8'hFA, 3'd1);
        wr(1'b1, 134, 8'hFA, 3'd1);
        rd_cnt(c); chk("R7 io decode and either window", c, 3);
    endtask

    task automatic t_ctrl;
        logic [7:0]  v;
        logic [31:0] c;
        sel(4);
        for (int k = 0; k < 3; k++) wr(1'b1, 132, 8'h11, 3'd1);
        rd_cnt(c); chk("R4 io wildcard", c, 3);
        wr(1'b1, 0, 8'h01, 3'd1);
        rd_cnt(c); chk("R3 reselect restarts count", c, 0);
        sel(3);
        wr(1'b1, 0, 8'hFA, 3'd1);
        rd(1'b0, 0, 3'd1, v);  chk("R3 value >=3 deactivates", 32'(v), 0);
        rd(1'b1, 12, 3'd1, v); chk("R3 inactive count read", 32'(v), 0);
        sel(4);
        wr(1'b1, 0, 8'h03, 3'd1);
        wr(1'b1, 132, 8'h00, 3'd1);
        wr(1'b1, 0, 8'h01, 3'd1);
        rd_cnt(c); chk("R6 inactive writes no count", c, 0);
    endtask

    task automatic t_carry;
        logic [7:0] v;
        sel(1);
        for (int k = 0; k < 257; k++) wr(1'b0, 2049, 8'(k), 3'd1);
        rd(1'b0, 12, 3'd1, v); chk("R9 count byte12", 32'(v), 8'h01);
        rd(1'b0, 13, 3'd1, v); chk("R9 count byte13", 32'(v), 8'h01);
        rd(1'b0, 14, 3'd1, v); chk("R9 count byte14", 32'(v), 8'h00);
        rd(1'b0, 15, 3'd1, v); chk("R9 count byte15", 32'(v), 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_name();
        t_wild();
        t_match();
        t_ctrl();
        t_carry();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule